// File: doc/BRIEF.md
# Compressed Instruction Refill Decompressor

This block sits between an instruction cache and main memory and runs only when the cache misses. It accepts the miss address together with a flag, taken from the page attributes, that marks the page as holding compressed code. On a plain page it reads the 64-byte block from memory and hands the sixteen words to the cache unchanged. On a compressed page it divides the miss address by the block size and uses the result to look up a table. The table entry gives the byte address where that block's compressed bit stream starts.

The stream is decoded one bit per clock. Each 32-bit instruction is rebuilt from two 16-bit halves. The upper half is decoded first, then the lower half, and each half has its own canonical prefix code. Software programs the code tables and the index table through a write port before execution. Each rebuilt instruction is written into the cache line with its word index. A done pulse closes the refill. A bit pattern that no code length accepts aborts the refill with an error pulse.

Top module: `refill_decomp`

## Requirements
- R1: After reset, `busy`, `fill_valid`, `fill_done`, `fill_err` and `mem_req` are all low.
- R2: On a compressed miss, the index entry read is `(miss_addr >> 6) mod IDX_DEPTH`. Its value is the byte address of a 32-bit word. The stream starts at bit 31 of that word, is consumed from the most significant bit down, and continues in the following words.
- R3: Table writes are selected by `tbl_kind`: 0 = first code, 1 = code count, 2 = symbol, 3 = index entry. `tbl_half` selects 0 = upper half, 1 = lower half. For kinds 0 and 1, `tbl_addr` holds the code length minus one (0..15). A code of length L (1..16) matches when first[L] <= code < first[L] + count[L]. Its symbol is entry (sum of the counts of all shorter lengths + code - first[L]) of that half's symbol array.
- R4: Each filled instruction is {upper symbol, lower symbol}. The upper symbol is decoded from the stream before the lower one.
- R5: A refill that completes produces exactly 16 `fill_valid` cycles, with `fill_idx` going 0, 1, ..., 15.
- R6: `fill_done` is a one-cycle pulse in the cycle after the fill with index 15.
- R7: On a miss with `miss_compressed` low, the 16 words at byte address `miss_addr` with its low 6 bits cleared are passed to the fill port unchanged and in address order.
- R8: If a half's code reaches 16 bits with no match, `fill_err` and `fill_done` pulse together for one cycle, and no further fill follows in that refill.
- R9: `mem_req` is a one-cycle pulse, and no new request is issued until `mem_rvalid` has returned the previous one.
- R10: `busy` is high from the cycle after a miss is accepted, through every fill, until the block is idle again. A later miss is then serviced normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_kind | input | 2 | Table select (R3) |
| tbl_half | input | 1 | Half select for code tables |
| tbl_addr | input | TBL_AW | Entry address |
| tbl_wdata | input | 32 | Write data (low 16 bits for code tables) |
| miss_req | input | 1 | Cache miss request, taken while idle |
| miss_addr | input | ADDR_W | Uncompressed miss byte address |
| miss_compressed | input | 1 | Page holds compressed code |
| mem_req | output | 1 | Memory read request pulse |
| mem_addr | output | ADDR_W | Memory read byte address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| fill_valid | output | 1 | Cache line word write |
| fill_idx | output | 4 | Word index in the line |
| fill_data | output | 32 | Instruction word |
| fill_done | output | 1 | Refill finished |
| fill_err | output | 1 | Undecodable code, refill aborted |
| busy | output | 1 | Refill in progress |

## Verification
An error in the bit buffer or in the length/base accumulation changes the symbol boundaries, so every later instruction of the line comes out wrong. This shows at the fill port within one or two words. It can also end in a false error pulse. A wrong index lookup or a wrong passthrough address corrupts the first filled word. A broken word counter shows up as a wrong `fill_idx`, or as a done pulse that comes early or never. Every word of every refill is compared, together with its index and the timing of the done pulse.

// File: rtl/refill_pkg.sv
package refill_pkg;
  localparam int HALF_W  = 16;
  localparam int INSTR_W = 32;
  localparam int MAX_LEN = 16;

  localparam logic [1:0] TK_FIRST = 2'd0;
  localparam logic [1:0] TK_COUNT = 2'd1;
  localparam logic [1:0] TK_SYM   = 2'd2;
  localparam logic [1:0] TK_INDEX = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOK, ST_PASS, ST_HI, ST_LO, ST_DRAIN
  } refill_st_e;

  typedef enum logic [1:0] {DS_IDLE, DS_RUN, DS_SYM} dec_st_e;
endpackage

// File: rtl/refill_index.sv
module refill_index #(
  parameter int IDX_DEPTH = 64,
  parameter int ADDR_W    = 32
) (
  input  logic                         clk,
  input  logic                         wr_en,
  input  logic [$clog2(IDX_DEPTH)-1:0] wr_addr,
  input  logic [ADDR_W-1:0]            wr_data,
  input  logic [$clog2(IDX_DEPTH)-1:0] rd_addr,
  output logic [ADDR_W-1:0]            rd_data
);
  logic [ADDR_W-1:0] mem_q [IDX_DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_data;
    rd_data <= mem_q[rd_addr];
  end
endmodule

// File: rtl/refill_fetch.sv
module refill_fetch #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              run,
  input  logic              pass,
  input  logic              consume,
  output logic              bit_valid,
  output logic              bit_out,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  output logic              outstanding
);
  localparam int BUF_W = 64;

  logic [BUF_W-1:0]  bits_q, shifted, placed;
  logic [6:0]        cnt_q, cnt_c;
  logic [ADDR_W-1:0] next_q;

  assign bit_valid = (cnt_q != 7'd0);
  assign bit_out   = bits_q[BUF_W-1];

  always_comb begin
    shifted = consume ? (bits_q << 1) : bits_q;
    cnt_c   = cnt_q - {6'd0, consume};
    placed  = {mem_rdata, 32'd0} >> cnt_c;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bits_q      <= '0;
      cnt_q       <= '0;
      next_q      <= '0;
      mem_addr    <= '0;
      mem_req     <= 1'b0;
      outstanding <= 1'b0;
    end else begin
      mem_req <= 1'b0;
      if (mem_rvalid) outstanding <= 1'b0;
      if (start) begin
        bits_q <= '0;
        cnt_q  <= '0;
        next_q <= start_addr;
      end else begin
        if (mem_rvalid && !pass) begin
          bits_q <= shifted | placed;
          cnt_q  <= cnt_c + 7'd32;
        end else begin
          bits_q <= shifted;
          cnt_q  <= cnt_c;
        end
        if (run && !outstanding && (pass || cnt_q < 7'd32)) begin
          mem_req     <= 1'b1;
          outstanding <= 1'b1;
          mem_addr    <= next_q;
          next_q      <= next_q + ADDR_W'(4);
        end
      end
    end
  end
endmodule

// File: rtl/refill_prefix_dec.sv
module refill_prefix_dec
  import refill_pkg::*;
#(
  parameter int SYM_DEPTH = 32,
  parameter int TBL_AW    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_kind,
  input  logic              wr_half,
  input  logic [TBL_AW-1:0] wr_addr,
  input  logic [HALF_W-1:0] wr_data,
  input  logic              start,
  input  logic              start_half,
  input  logic              bit_valid,
  input  logic              bit_in,
  output logic              consume,
  output logic              sym_valid,
  output logic [HALF_W-1:0] sym,
  output logic              err
);
  localparam int SYM_AW = $clog2(SYM_DEPTH);
  localparam int LEN_W  = $clog2(MAX_LEN);

  dec_st_e           st_q;
  logic              half_q;
  logic [HALF_W-1:0] code_q, base_q, cand, diff, f_cur, n_cur;
  logic [LEN_W-1:0]  len_q;
  logic              hit;
  logic [SYM_AW-1:0] rd_addr;
  logic [HALF_W-1:0] first_q [2][MAX_LEN];
  logic [HALF_W-1:0] count_q [2][MAX_LEN];
  logic [1:0][HALF_W-1:0] rd_all;

  always_ff @(posedge clk) begin
    if (wr_en && wr_kind == TK_FIRST) first_q[wr_half][wr_addr[LEN_W-1:0]] <= wr_data;
    if (wr_en && wr_kind == TK_COUNT) count_q[wr_half][wr_addr[LEN_W-1:0]] <= wr_data;
  end

  always_comb begin
    cand    = {code_q[HALF_W-2:0], bit_in};
    f_cur   = first_q[half_q][len_q];
    n_cur   = count_q[half_q][len_q];
    diff    = cand - f_cur;
    hit     = (cand >= f_cur) && (diff < n_cur);
    consume = (st_q == DS_RUN) && bit_valid;
    rd_addr = SYM_AW'(base_q + diff);
    err     = consume && !hit && (len_q == LEN_W'(MAX_LEN - 1));
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [HALF_W-1:0] sym_mem [SYM_DEPTH];
    logic [HALF_W-1:0] rd_q;
    always_ff @(posedge clk) begin
      if (wr_en && wr_kind == TK_SYM && wr_half == h[0])
        sym_mem[wr_addr[SYM_AW-1:0]] <= wr_data;
      rd_q <= sym_mem[rd_addr];
    end
    assign rd_all[h] = rd_q;
  end

  assign sym_valid = (st_q == DS_SYM);
  assign sym       = rd_all[half_q];

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= DS_IDLE;
      half_q <= 1'b0;
      code_q <= '0;
      base_q <= '0;
      len_q  <= '0;
    end else if (start) begin
      st_q   <= DS_RUN;
      half_q <= start_half;
      code_q <= '0;
      base_q <= '0;
      len_q  <= '0;
    end else begin
      case (st_q)
        DS_RUN: if (consume) begin
          if (hit) st_q <= DS_SYM;
          else if (err) st_q <= DS_IDLE;
          else begin
            code_q <= cand;
            len_q  <= len_q + 1'b1;
            base_q <= base_q + n_cur;
          end
        end
        DS_SYM:  st_q <= DS_IDLE;
        default: st_q <= DS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/refill_decomp.sv
module refill_decomp
  import refill_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int IDX_DEPTH  = 64,
  parameter int SYM_DEPTH  = 32,
  parameter int TBL_AW     = 8,
  parameter int LINE_WORDS = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          tbl_we,
  input  logic [1:0]                    tbl_kind,
  input  logic                          tbl_half,
  input  logic [TBL_AW-1:0]             tbl_addr,
  input  logic [31:0]                   tbl_wdata,
  input  logic                          miss_req,
  input  logic [ADDR_W-1:0]             miss_addr,
  input  logic                          miss_compressed,
  output logic                          mem_req,
  output logic [ADDR_W-1:0]             mem_addr,
  input  logic                          mem_rvalid,
  input  logic [31:0]                   mem_rdata,
  output logic                          fill_valid,
  output logic [$clog2(LINE_WORDS)-1:0] fill_idx,
  output logic [INSTR_W-1:0]            fill_data,
  output logic                          fill_done,
  output logic                          fill_err,
  output logic                          busy
);
  localparam int IDX_AW = $clog2(IDX_DEPTH);
  localparam int WI_W   = $clog2(LINE_WORDS);
  localparam int OFS_W  = $clog2(LINE_WORDS * 4);
  localparam logic [WI_W-1:0] LAST = WI_W'(LINE_WORDS - 1);

  refill_st_e        st_q;
  logic [WI_W-1:0]   word_q;
  logic [HALF_W-1:0] hi_q;
  logic [ADDR_W-1:0] idx_rd, fetch_addr;
  logic              fetch_start, run, pass, consume, bit_valid, bit_in, outstanding;
  logic              dec_start, dec_half, sym_valid, dec_err;
  logic [HALF_W-1:0] sym;

  always_comb begin
    fetch_start = (st_q == ST_IDLE && miss_req && !miss_compressed) || (st_q == ST_LOOK);
    fetch_addr  = (st_q == ST_LOOK) ? idx_rd : {miss_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
    run         = (st_q == ST_PASS) || (st_q == ST_HI) || (st_q == ST_LO);
    pass        = (st_q == ST_PASS);
    dec_start   = (st_q == ST_LOOK) || (st_q == ST_HI && sym_valid) ||
                  (st_q == ST_LO && sym_valid && word_q != LAST);
    dec_half    = (st_q == ST_HI);
  end

  assign busy = (st_q != ST_IDLE);

  refill_index #(.IDX_DEPTH(IDX_DEPTH), .ADDR_W(ADDR_W)) u_index (
    .clk     (clk),
    .wr_en   (tbl_we && tbl_kind == TK_INDEX),
    .wr_addr (tbl_addr[IDX_AW-1:0]),
    .wr_data (tbl_wdata[ADDR_W-1:0]),
    .rd_addr (miss_addr[OFS_W +: IDX_AW]),
    .rd_data (idx_rd)
  );

  refill_fetch #(.ADDR_W(ADDR_W)) u_fetch (
    .clk         (clk),
    .rst         (rst),
    .start       (fetch_start),
    .start_addr  (fetch_addr),
    .run         (run),
    .pass        (pass),
    .consume     (consume),
    .bit_valid   (bit_valid),
    .bit_out     (bit_in),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_rvalid  (mem_rvalid),
    .mem_rdata   (mem_rdata),
    .outstanding (outstanding)
  );

  refill_prefix_dec #(.SYM_DEPTH(SYM_DEPTH), .TBL_AW(TBL_AW)) u_dec (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (tbl_we),
    .wr_kind    (tbl_kind),
    .wr_half    (tbl_half),
    .wr_addr    (tbl_addr),
    .wr_data    (tbl_wdata[HALF_W-1:0]),
    .start      (dec_start),
    .start_half (dec_half),
    .bit_valid  (bit_valid),
    .bit_in     (bit_in),
    .consume    (consume),
    .sym_valid  (sym_valid),
    .sym        (sym),
    .err        (dec_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      word_q     <= '0;
      hi_q       <= '0;
      fill_valid <= 1'b0;
      fill_idx   <= '0;
      fill_data  <= '0;
      fill_done  <= 1'b0;
      fill_err   <= 1'b0;
    end else begin
      fill_valid <= 1'b0;
      fill_err   <= 1'b0;
      fill_done  <= fill_valid && (fill_idx == LAST);
      case (st_q)
        ST_IDLE: if (miss_req) begin
          word_q <= '0;
          st_q   <= miss_compressed ? ST_LOOK : ST_PASS;
        end
        ST_LOOK: st_q <= ST_HI;
        ST_PASS: if (mem_rvalid) begin
          fill_valid <= 1'b1;
          fill_data  <= mem_rdata;
          fill_idx   <= word_q;
          word_q     <= word_q + 1'b1;
          if (word_q == LAST) st_q <= ST_DRAIN;
        end
        ST_HI, ST_LO: begin
          if (dec_err) begin
            fill_err  <= 1'b1;
            fill_done <= 1'b1;
            st_q      <= ST_DRAIN;
          end else if (sym_valid) begin
            if (st_q == ST_HI) begin
              hi_q <= sym;
              st_q <= ST_LO;
            end else begin
              fill_valid <= 1'b1;
              fill_data  <= {hi_q, sym};
              fill_idx   <= word_q;
              word_q     <= word_q + 1'b1;
              st_q       <= (word_q == LAST) ? ST_DRAIN : ST_HI;
            end
          end
        end
        ST_DRAIN: if (!outstanding) st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/refill_decomp_chk.sv
module refill_decomp_chk #(
  parameter int LINE_WORDS = 16
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          miss_req,
  input logic                          busy,
  input logic                          mem_req,
  input logic                          mem_rvalid,
  input logic                          fill_valid,
  input logic [$clog2(LINE_WORDS)-1:0] fill_idx,
  input logic                          fill_done,
  input logic                          fill_err
);
  localparam int WI_W = $clog2(LINE_WORDS);
  localparam logic [WI_W-1:0] LAST = WI_W'(LINE_WORDS - 1);

  logic            pend_q;
  logic [WI_W-1:0] exp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      exp_q  <= '0;
    end else begin
      if (mem_req) pend_q <= 1'b1;
      else if (mem_rvalid) pend_q <= 1'b0;
      if (miss_req && !busy) exp_q <= '0;
      else if (fill_valid) exp_q <= exp_q + 1'b1;
    end
  end

  // R9
  single_req_chk: assert property (@(posedge clk) disable iff (rst) mem_req |-> !pend_q);
  // R9
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst) mem_req |=> !mem_req);
  // R5
  fill_order_chk: assert property (@(posedge clk) disable iff (rst) fill_valid |-> fill_idx == exp_q);
  // R6
  done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    (fill_valid && fill_idx == LAST) |=> (fill_done && !fill_err));
  // R8
  err_ends_chk: assert property (@(posedge clk) disable iff (rst) fill_err |-> (fill_done && !fill_valid));
  // R8
  no_fill_after_err_chk: assert property (@(posedge clk) disable iff (rst) fill_err |=> !fill_valid);
  // R10
  fill_busy_chk: assert property (@(posedge clk) disable iff (rst) fill_valid |-> busy);
endmodule

bind refill_decomp refill_decomp_chk #(.LINE_WORDS(LINE_WORDS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .miss_req   (miss_req),
  .busy       (busy),
  .mem_req    (mem_req),
  .mem_rvalid (mem_rvalid),
  .fill_valid (fill_valid),
  .fill_idx   (fill_idx),
  .fill_done  (fill_done),
  .fill_err   (fill_err)
);

// File: tb/refill_decomp_tb.sv
module refill_decomp_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tbl_we = 1'b0;
  logic [1:0]  tbl_kind = '0;
  logic        tbl_half = 1'b0;
  logic [7:0]  tbl_addr = '0;
  logic [31:0] tbl_wdata = '0;
  logic        miss_req = 1'b0;
  logic [31:0] miss_addr = '0;
  logic        miss_compressed = 1'b0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;
  logic        fill_valid;
  logic [3:0]  fill_idx;
  logic [31:0] fill_data;
  logic        fill_done, fill_err, busy;

  always #2ns clk = ~clk;

  refill_decomp u_dut (.*);

  int n_chk = 0, n_fail = 0;
  logic [31:0] memw [1024];

  // memory model: one or two cycles of latency depending on address bit 2
  logic       pend = 1'b0;
  logic [9:0] paddr;
  int         lat, overlap = 0;
  always @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0; mem_rvalid <= 1'b0; mem_rdata <= '0;
    end else begin
      mem_rvalid <= 1'b0;
      if (pend) begin
        if (lat == 0) begin mem_rvalid <= 1'b1; mem_rdata <= memw[paddr]; pend <= 1'b0; end
        else lat <= lat - 1;
      end
      if (mem_req) begin
        if (pend) overlap <= overlap + 1;
        pend <= 1'b1; paddr <= mem_addr[11:2]; lat <= int'(mem_addr[2]);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // code tables, symbols ordered by code length (canonical)
  int          hi_len[5]  = '{1, 2, 3, 4, 4};
  int          hi_code[5] = '{0, 2, 6, 14, 15};
  int          lo_len[5]  = '{2, 2, 2, 3, 16};
  int          lo_code[5] = '{0, 1, 2, 6, 'hE000};
  logic [15:0] hi_sym[5]  = '{16'h1234, 16'hABCD, 16'h0000, 16'hFFFF, 16'h8001};
  logic [15:0] lo_sym[5]  = '{16'h0001, 16'h0002, 16'h7FFF, 16'hC3C3, 16'h5A5A};

  task automatic twrite(input logic [1:0] k, input logic h, input int a, input logic [31:0] d);
    @(negedge clk);
    tbl_we = 1'b1; tbl_kind = k; tbl_half = h; tbl_addr = 8'(a); tbl_wdata = d;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic load_half(input logic h);
    int code = 0;
    for (int l = 1; l <= 16; l++) begin
      int cnt = 0;
      for (int s = 0; s < 5; s++) if ((h ? lo_len[s] : hi_len[s]) == l) cnt++;
      twrite(2'd0, h, l - 1, 32'(code & 'hFFFF));
      twrite(2'd1, h, l - 1, 32'(cnt));
      code = (code + cnt) << 1;
    end
    for (int s = 0; s < 5; s++) twrite(2'd2, h, s, {16'd0, h ? lo_sym[s] : hi_sym[s]});
  endtask

  int bp;
  task automatic put(input int wbase, input int code, input int len);
    for (int b = len - 1; b >= 0; b--) begin
      memw[wbase + bp / 32][31 - bp % 32] = code[b];
      bp++;
    end
  endtask

  logic [31:0] uexp[4][16];
  // mode 0/1: sweep of all hi/lo pairs, mode 2: every lower half 16 bits long
  task automatic build_unit(input int wbase, input int mode, input int u);
    bp = 0;
    for (int k = 0; k < 16; k++) begin
      int n = mode * 16 + k;
      int hs = (mode == 2) ? k % 5 : n % 5;
      int ls = (mode == 2) ? 4 : (n / 5) % 5;
      put(wbase, hi_code[hs], hi_len[hs]);
      put(wbase, lo_code[ls], lo_len[ls]);
      uexp[u][k] = {hi_sym[hs], lo_sym[ls]};
    end
  endtask

  // fill monitor
  logic [31:0] got[16];
  int  nfill, order_bad, done_bad;
  bit  done_seen, err_seen, prev_v;
  logic [3:0] prev_i;
  always @(negedge clk) begin
    if (!rst) begin
      if (fill_valid) begin
        if (int'(fill_idx) != nfill) order_bad++;
        if (nfill < 16) got[nfill] = fill_data;
        nfill++;
      end
      if (fill_done) begin
        done_seen = 1'b1;
        if (!fill_err && !(prev_v && prev_i == 4'd15)) done_bad++;
      end
      if (fill_err) err_seen = 1'b1;
      prev_v = fill_valid; prev_i = fill_idx;
    end
  end

  task automatic run_miss(input logic [31:0] a, input bit comp, input int en,
                          input bit eerr, input int u, input bit pass_ref, input string req);
    int guard = 0;
    nfill = 0; order_bad = 0; done_bad = 0; done_seen = 0; err_seen = 0;
    @(negedge clk);
    miss_req = 1'b1; miss_addr = a; miss_compressed = comp;
    @(negedge clk);
    miss_req = 1'b0;
    chk(busy, "R10", "busy after accept", 32'(busy), 1);
    while (!done_seen && guard < 4000) begin @(negedge clk); guard++; end
    while (busy && guard < 4000) begin @(negedge clk); guard++; end
    repeat (3) @(negedge clk);
    chk(!busy, "R10", "idle after refill", 32'(busy), 0);
    chk(nfill == en, eerr ? "R8" : "R5", "fill count", 32'(nfill), 32'(en));
    chk(order_bad == 0, "R5", "fill index order", 32'(order_bad), 0);
    chk(done_seen && done_bad == 0, "R6", "done pulse timing", 32'(done_bad), 0);
    chk(err_seen == eerr, "R8", "error flag", 32'(err_seen), 32'(eerr));
    for (int k = 0; k < en && k < 16; k++) begin
      logic [31:0] e = pass_ref ? memw[{a[11:6], 4'd0} + k] : uexp[u][k];
      chk(got[k] === e, req, $sformatf("word %0d", k), got[k], e);
    end
  endtask

  bit finished = 1'b0;
  initial begin
    #(4ns * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) memw[i] = (i * 32'h9E3779B1) ^ 32'h5A5A0000;
    for (int i = 16'h40; i < 16'h280; i++) memw[i] = '0;
    build_unit(16'h100 / 4, 0, 0);
    build_unit(16'h300 / 4, 1, 1);
    build_unit(16'h600 / 4, 2, 2);
    // error unit: two good instructions, then an upper half and a 16-bit miss
    bp = 0;
    put(16'h900 / 4, hi_code[0], hi_len[0]); put(16'h900 / 4, lo_code[0], lo_len[0]);
    put(16'h900 / 4, hi_code[1], hi_len[1]); put(16'h900 / 4, lo_code[1], lo_len[1]);
    put(16'h900 / 4, hi_code[2], hi_len[2]); put(16'h900 / 4, 'hFFFF, 16);
    uexp[3][0] = {hi_sym[0], lo_sym[0]};
    uexp[3][1] = {hi_sym[1], lo_sym[1]};

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy, "R1", "busy after reset", 32'(busy), 0);
    chk(!fill_valid && !fill_done && !fill_err, "R1", "fill outputs after reset",
        {29'd0, fill_valid, fill_done, fill_err}, 0);
    chk(!mem_req, "R1", "mem_req after reset", 32'(mem_req), 0);

    load_half(1'b0);
    load_half(1'b1);
    twrite(2'd3, 1'b0, 3,  32'h100);
    twrite(2'd3, 1'b0, 7,  32'h300);
    twrite(2'd3, 1'b0, 12, 32'h600);
    twrite(2'd3, 1'b0, 20, 32'h900);

    run_miss(32'hA48,  1'b0, 16, 1'b0, 0, 1'b1, "R7");   // plain page passthrough
    run_miss(32'h0D4,  1'b1, 16, 1'b0, 0, 1'b0, "R3");   // sweep part 1 (R2 R4)
    run_miss(32'h1FC,  1'b1, 16, 1'b0, 1, 1'b0, "R4");   // sweep part 2
    run_miss(32'h320,  1'b1, 16, 1'b0, 2, 1'b0, "R3");   // 16-bit lower codes
    run_miss(32'h10C0, 1'b1, 16, 1'b0, 0, 1'b0, "R2");   // entry index wraps to 3
    run_miss(32'h500,  1'b1, 2,  1'b1, 3, 1'b0, "R8");   // undecodable code
    run_miss(32'h1C0,  1'b1, 16, 1'b0, 1, 1'b0, "R10");  // normal after error
    run_miss(32'hA40,  1'b0, 16, 1'b0, 0, 1'b1, "R7");
    chk(overlap == 0, "R9", "overlapping memory requests", 32'(overlap), 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule